// File: doc/BRIEF.md
# Interlocked Asynchronous Bus Read Controller

This block is the requesting side of a fully interlocked, four-phase read on an asynchronous memory bus. A local client pulses a start line together with an address. The controller places the address on the bus and asserts the memory-select strobe with the direction line at read. After a programmable setup time it raises its request-valid strobe. It then waits for the responder's acknowledge strobe. That strobe arrives asynchronously, so it is resynchronized inside the block.

Once the synchronized acknowledge is seen, the controller copies the bus data into a holding register and lowers the request-valid strobe. On the next clock it releases the select, direction and address lines. It then waits for the acknowledge to return low before it reports completion with a single-clock done pulse. At that point every bus line is idle, and a new read may start in the same cycle that done is shown. A start that arrives while a read is under way is dropped.

Top module: `async_rd_master`

## Requirements
- R1: A read drives the latched start address on `bus_addr_o`, sets `bus_sel_o` to 1 and `bus_rw_o` to 0 (0 = read, 1 = idle/write level), and holds these values for as long as `bus_req_o` is high.
- R2: `bus_req_o` rises exactly SETUP_CYC clocks after `bus_sel_o` rises. Select, direction and address are already valid on the clock before the rise.
- R3: The value in `rdata_o` at done equals the bus data present while `bus_ack_i` is high. Data driven on the bus before the acknowledge never reaches `rdata_o`.
- R4: `bus_ack_i` passes through a SYNC_N-flop synchronizer. `bus_req_o` falls on the (SYNC_N+1)-th rising clock edge after a rise of `bus_ack_i` applied between edges.
- R5: Withdrawal is ordered. `bus_req_o` falls while `bus_sel_o`, `bus_rw_o` and `bus_addr_o` keep their read values. Those three lines return to idle one clock later.
- R6: `done_o` is a one-clock pulse. It is raised only after the synchronized acknowledge has returned low, and `bus_ack_i` is low whenever `done_o` is high.
- R7: While `done_o` is high, the bus outputs are idle: address 0, select 0, direction 1, request 0. A start given in that cycle begins a new read.
- R8: A start asserted while `busy_o` is high is ignored. No extra bus cycle follows, and the address of the running read is not changed.
- R9: During reset all bus outputs are idle, and `done_o`, `busy_o` and `rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a read (sampled when idle) |
| addr_i | input | AW | Read address, latched with start |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DW | Captured read data |
| busy_o | output | 1 | A read is in progress |
| bus_addr_o | output | AW | Bus address lines |
| bus_sel_o | output | 1 | Memory-select strobe |
| bus_rw_o | output | 1 | Direction line, 0 = read |
| bus_req_o | output | 1 | Master request-valid strobe |
| bus_ack_i | input | 1 | Responder acknowledge strobe (asynchronous) |
| bus_data_i | input | DW | Bus data lines |

## Verification
The responder model answers with random delays, from zero up to many clocks, before raising and before dropping its acknowledge. While the acknowledge is low it drives random data, so any early capture shows up as a wrong read value and separates correct sampling (R3) from a premature one. A directed run with zero delays tests the tightest timing of the synchronizer count (R4) and of back-to-back reads (R7). A long-delay run tests that done is held back until the acknowledge falls (R6). Starts injected at random points of a running read tell apart a controller that ignores them (R8) from one that relatches the address or adds a bus cycle.

// File: rtl/async_rd_master.sv
module async_rd_master #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int SETUP_CYC = 1,
  parameter int SYNC_N    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_sel_o,
  output logic          bus_rw_o,
  output logic          bus_req_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_data_i
);
  localparam int CW = (SETUP_CYC < 2) ? 1 : $clog2(SETUP_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETUP_CYC - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_WAIT, ST_DROP, ST_REL} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [SYNC_N-1:0] ack_q;
  logic           ack_s;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  mbr_q;
  logic           done_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ack_q <= '0;
    else        ack_q <= {ack_q[SYNC_N-2:0], bus_ack_i};

  assign ack_s = ack_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      mbr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE:
          if (start_i) begin
            addr_q <= addr_i;
            cnt    <= '0;
            st     <= ST_SETUP;
          end
        ST_SETUP:
          if (cnt == CNT_LAST) st <= ST_WAIT;
          else                 cnt <= cnt + 1'b1;
        ST_WAIT:
          if (ack_s) begin
            mbr_q <= bus_data_i;
            st    <= ST_DROP;
          end
        ST_DROP: begin
          addr_q <= '0;
          st     <= ST_REL;
        end
        ST_REL:
          if (!ack_s) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign bus_sel_o  = (st == ST_SETUP) || (st == ST_WAIT) || (st == ST_DROP);
  assign bus_rw_o   = !bus_sel_o;
  assign bus_req_o  = (st == ST_WAIT);
  assign bus_addr_o = addr_q;
  assign busy_o     = (st != ST_IDLE);
  assign done_o     = done_q;
  assign rdata_o    = mbr_q;

  // R2
  req_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_o) |-> $past(bus_sel_o) && !$past(bus_rw_o));

  // R1
  req_lines_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && $past(bus_req_o) |->
      $stable(bus_addr_o) && $stable(bus_sel_o) && $stable(bus_rw_o));

  // R5
  sel_release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_sel_o) |-> !$past(bus_req_o));

  // R7
  done_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !bus_sel_o && !bus_req_o && bus_rw_o && (bus_addr_o == '0));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3
  capture_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o != $past(rdata_o)) |-> $past(ack_s) && $past(bus_req_o));
endmodule

// File: tb/sim_async_rd_master.sv
module sim_async_rd_master;
  localparam int AW = 16, DW = 16, SETUP_CYC = 1, SYNC_N = 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] addr = '0;
  logic done, busy, sel, rw, req;
  logic [DW-1:0] rdata;
  logic [AW-1:0] baddr;
  logic ack = 0;
  logic [DW-1:0] bdata = '0;

  int total = 0, bad = 0;
  int cyc = 0, t_ack = 0, gap = 0;
  int n_seen = 0, n_issued = 0;
  int dly_max = 5;
  logic [AW-1:0] cur_addr = '0, seen_addr = '0;
  logic p_sel = 0, p_req = 0, p_rw = 1, p_done = 0;
  logic [AW-1:0] p_addr = '0;

  always #10 clk = ~clk;

  async_rd_master #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .SYNC_N(SYNC_N)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
    .done_o(done), .rdata_o(rdata), .busy_o(busy),
    .bus_addr_o(baddr), .bus_sel_o(sel), .bus_rw_o(rw), .bus_req_o(req),
    .bus_ack_i(ack), .bus_data_i(bdata));

  function automatic logic [DW-1:0] mem_f(logic [AW-1:0] a);
    return DW'(a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(0, "watchdog", 32'(cyc), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // responder model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req && sel && !rw) begin
        seen_addr = baddr;
        n_seen++;
        repeat ($urandom_range(dly_max, 0)) begin
          bdata = DW'($urandom);
          @(negedge clk);
        end
        bdata = mem_f(seen_addr);
        ack = 1;
        t_ack = cyc;
        do @(negedge clk); while (req);
        repeat ($urandom_range(dly_max, 0)) @(negedge clk);
        ack = 0;
        bdata = DW'($urandom);
      end else if (!ack) begin
        bdata = DW'($urandom);
      end
    end
  end

  // bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (sel && !p_sel) gap = 1;
      else if (sel && !req && !p_req) gap++;
      if (req && !p_req) begin
        chk(p_sel && !p_rw, "R2 setup lines before req", {p_sel, p_rw}, 2'b10);
        chk(gap == SETUP_CYC, "R2 setup gap", 32'(gap), SETUP_CYC);
        chk(baddr == cur_addr, "R1 address", baddr, cur_addr);
        chk(sel && !rw, "R1 sel/rw", {sel, rw}, 2'b10);
      end
      if (req && p_req)
        chk(baddr == p_addr && sel == p_sel && rw == p_rw, "R1 stable while req",
            {baddr, sel, rw}, {p_addr, p_sel, p_rw});
      if (p_req && !req) begin
        chk(sel && !rw && baddr == p_addr, "R5 req drops first", {baddr, sel, rw},
            {p_addr, 2'b10});
        chk(cyc - t_ack == SYNC_N + 1, "R4 sync latency", 32'(cyc - t_ack), SYNC_N + 1);
      end
      if (p_sel && !sel)
        chk(!p_req, "R5 sel after req", 32'(p_req), 0);
      if (done) begin
        chk(!ack, "R6 ack low at done", 32'(ack), 0);
        chk(!sel && !req && rw && baddr == '0, "R7 idle at done",
            {baddr, sel, rw, req}, {16'h0, 3'b010});
        chk(!p_done, "R6 single pulse", 32'(p_done), 0);
      end
    end
    p_sel = sel; p_req = req; p_rw = rw; p_done = done; p_addr = baddr;
  end

  task automatic do_read(logic [AW-1:0] a, bit poke);
    int n;
    bit got;
    start = 1; addr = a; cur_addr = a; n_issued++;
    @(negedge clk);
    start = 0;
    n = 0; got = 0;
    while (!got && n < 400) begin
      if (poke && busy && $urandom_range(3, 0) == 0) begin
        start = 1; addr = ~a;
      end else begin
        start = 0;
      end
      @(negedge clk);
      n++;
      if (done) got = 1;
    end
    start = 0;
    chk(got, "R6 done seen", 32'(got), 1);
    chk(rdata == mem_f(a), "R3 read data", rdata, mem_f(a));
    chk(seen_addr == a, "R8 address unchanged", seen_addr, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!sel && !req && rw && baddr == '0 && !done && !busy && rdata == '0,
        "R9 reset state", {baddr, sel, rw, req, done, busy}, {16'h0, 5'b01000});
    rst_n = 1;
    @(negedge clk);
    dly_max = 0;
    do_read(16'h1234, 0);
    do_read(16'hFFFF, 0);
    do_read(16'h0000, 0);
    dly_max = 30;
    do_read(16'hA5A5, 1);
    dly_max = 6;
    for (int i = 0; i < 60; i++) begin
      do_read(AW'($urandom), i[0]);
      if (i % 7 == 3) repeat ($urandom_range(4, 1)) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    chk(!sel && !busy, "R8 no extra cycle", {sel, busy}, 0);
    chk(n_seen == n_issued, "R8 bus cycle count", 32'(n_seen), 32'(n_issued));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd7);
  end
endmodule